// File: doc/BRIEF.md
# Balanced 16-to-20 Bit Parallel Word Encoder

The encoder accepts one 16-bit data word per clock cycle and, one cycle later, drives a 20-bit code word that always carries exactly ten ones and ten zeros. Every word on the bus therefore draws the same current and switches a balanced number of wires. The data-to-code mapping is a ranked enumeration. Data value d becomes the d-th member, counted from zero in ascending numeric order, of a set of permitted words. That member is found by a chain of twenty combinational digit-selection steps. Their path-count constants are computed at elaboration, so no table is stored.

The receiver can detect each new word by change alone, because no two consecutive emitted words are ever equal. When a data word repeats, the encoder does not send the same code twice. It sends one of two reserved repeat words and alternates between them on a run of repeats. A dedicated balanced sync word contains a run of eight ones. No permitted word contains such a run, and none can form one across the seam between two permitted words. The sync word therefore cannot be mistaken for any alignment of ordinary traffic in a serial stream.

Top module: `bal_word_enc`

## Requirements
- R1: Every word emitted with out_valid high has exactly ten one bits among its twenty.
- R2: For a data word d that is not a repeat, the emitted code is the d-th word (counting from 0, ascending numeric value) of the set of 20-bit words with ten ones, no run of identical bits longer than 7, a first run of at most 3 bits and a last run of at most 3 bits.
- R3: Two consecutive emitted words (ignoring idle cycles between them) are never equal.
- R4: Every emitted word other than the sync word has no run longer than 7, a first run of at most 4 and a last run of at most 3.
- R5: If a valid data word equals the last encoded data word and no sync was emitted since, the repeat word 20'hF0F0A is emitted. The exception is when the previous emitted word was 20'hF0F0A: then 20'h0F0F5 is emitted.
- R6: sync_req has priority over in_valid, and data presented in the same cycle is dropped. The sync word 20'hFF003 is emitted unless the last emitted word was already the sync word; in that case nothing is emitted.
- R7: The first data word after a sync word (or after reset) is always sent with its ranked code, never a repeat word.
- R8: A word presented at an edge appears on out_code with out_valid high one cycle later. A cycle with neither in_valid nor sync_req gives out_valid low, and out_code holds its value.
- R9: During and after reset, out_code is 20'hFF003 and out_valid is low. The encoder then behaves as if the sync word was last emitted and no data word is stored.
- R10: No 20-bit window spanning the seam of two consecutive emitted non-sync words equals the sync word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A data word is presented this cycle |
| in_data | input | 16 | Data word to encode |
| sync_req | input | 1 | Request to emit the sync word (overrides in_valid) |
| out_code | output | 20 | Balanced code word |
| out_valid | output | 1 | out_code carries a newly emitted word this cycle |

## Verification
The timing properties assume that in_valid and sync_req are known (never X) on every edge after reset. They also assume in_data is stable and known whenever in_valid is high, since the repeat decision compares it against the stored word. The bench drives every input on the falling edge from a prepared list, holds all of them at defined values throughout reset, and never leaves them floating. The stimulus places repeats, back-to-back sync requests, syncs with data in the same cycle and idle gaps between repeats at chosen points. The bench builds its expected codes by brute-force enumeration of all 20-bit words against the rule in R2.

// File: rtl/bwe_pkg.sv
package bwe_pkg;

    localparam int DATA_W   = 16;
    localparam int CODE_W   = 20;
    localparam int ONES     = CODE_W / 2;
    localparam int RUN_MAX  = 7;
    localparam int EDGE_MAX = 3;
    // First run is counted from this offset so the interior cap also limits it
    localparam int LEAD_OFS = RUN_MAX - EDGE_MAX;
    localparam int CNT_W    = 18;
    localparam int K_N      = ONES + 1;
    localparam int CELLS    = K_N * 2 * RUN_MAX;
    localparam int ROW_W    = CELLS * CNT_W;
    localparam int KW       = $clog2(ONES + 1);
    localparam int RW       = $clog2(RUN_MAX + 1);

    // Run of eight ones: cannot occur in, or across a seam of, emitted words
    localparam logic [CODE_W-1:0] SYNC_WORD = 20'hFF003;
    // First run of four sets the repeat words apart from ranked codes
    localparam logic [CODE_W-1:0] REP_WORD0 = 20'hF0F0A;
    localparam logic [CODE_W-1:0] REP_WORD1 = 20'h0F0F5;

    typedef enum logic [1:0] {
        EMIT_SYNC,
        EMIT_DATA,
        EMIT_REP0,
        EMIT_REP1
    } emit_kind_e;

    // State carried between digit-selection steps
    typedef struct packed {
        logic [CNT_W-1:0] rem;    // rank still to be consumed
        logic [KW-1:0]    ones;   // ones still to be placed
        logic             bit_v;  // value of the last placed bit
        logic [RW-1:0]    run;    // length of the current run, 0 = nothing placed
    } walk_t;

    function automatic int cell_idx(int k, int b, int r);
        return (k * 2 + b) * RUN_MAX + (r - 1);
    endfunction

    // Completion counts for a suffix of length len, for every (ones, bit, run)
    function automatic logic [ROW_W-1:0] count_row(int len);
        int cur [CELLS];
        int nxt [CELLS];
        int tot;
        logic [ROW_W-1:0] row;
        for (int k = 0; k < K_N; k++)
            for (int b = 0; b < 2; b++)
                for (int r = 1; r <= RUN_MAX; r++)
                    cur[cell_idx(k, b, r)] = (k == 0 && r <= EDGE_MAX) ? 1 : 0;
        for (int l = 1; l <= len; l++) begin
            for (int k = 0; k < K_N; k++)
                for (int b = 0; b < 2; b++)
                    for (int r = 1; r <= RUN_MAX; r++) begin
                        tot = 0;
                        if (r < RUN_MAX && k >= b)
                            tot += cur[cell_idx(k - b, b, r + 1)];
                        if (k >= 1 - b)
                            tot += cur[cell_idx(k - (1 - b), 1 - b, 1)];
                        nxt[cell_idx(k, b, r)] = tot;
                    end
            cur = nxt;
        end
        row = '0;
        for (int i = 0; i < CELLS; i++)
            row[i*CNT_W +: CNT_W] = CNT_W'(cur[i]);
        return row;
    endfunction

    function automatic int longest_run(logic [CODE_W-1:0] w);
        int run;
        int best;
        run  = 1;
        best = 1;
        for (int i = CODE_W - 2; i >= 0; i--) begin
            run = (w[i] == w[i+1]) ? run + 1 : 1;
            if (run > best) best = run;
        end
        return best;
    endfunction

    function automatic int first_run(logic [CODE_W-1:0] w);
        int n;
        n = 1;
        for (int i = CODE_W - 2; i >= 0; i--) begin
            if (w[i] != w[CODE_W-1]) return n;
            n++;
        end
        return n;
    endfunction

    function automatic int last_run(logic [CODE_W-1:0] w);
        int n;
        n = 1;
        for (int i = 1; i < CODE_W; i++) begin
            if (w[i] != w[0]) return n;
            n++;
        end
        return n;
    endfunction

    function automatic logic seam_holds_sync(logic [2*CODE_W-1:0] pair);
        for (int sh = 1; sh < CODE_W; sh++)
            if (pair[sh +: CODE_W] == SYNC_WORD) return 1'b1;
        return 1'b0;
    endfunction

endpackage

// File: rtl/bwe_rank_stage.sv
module bwe_rank_stage
    import bwe_pkg::*;
#(
    parameter int STEP = 0
) (
    input  walk_t w_in,
    output walk_t w_out,
    output logic  bit_o
);

    localparam int REMAIN = CODE_W - 1 - STEP;
    localparam logic [ROW_W-1:0] ROW = count_row(REMAIN);

    logic [RW-1:0]    run0;
    logic [RW-1:0]    run1;
    logic             ok0;
    logic [CNT_W-1:0] cnt0;
    logic             take1;

    // Completions when a zero is placed here (ones left k, zero run r)
    function automatic logic [CNT_W-1:0] zero_count(logic [KW-1:0] k, logic [RW-1:0] r);
        int idx;
        if (k > KW'(ONES) || r == '0) return '0;
        idx = (int'(k) * 2) * RUN_MAX + int'(r) - 1;
        return ROW[idx*CNT_W +: CNT_W];
    endfunction

    always_comb begin
        ok0 = 1'b1;
        if (w_in.run == '0)
            run0 = RW'(LEAD_OFS + 1);
        else if (w_in.bit_v)
            run0 = RW'(1);
        else if (w_in.run == RW'(RUN_MAX)) begin
            run0 = '0;
            ok0  = 1'b0;
        end else
            run0 = w_in.run + 1'b1;

        if (w_in.run == '0)
            run1 = RW'(LEAD_OFS + 1);
        else if (!w_in.bit_v)
            run1 = RW'(1);
        else
            run1 = w_in.run + 1'b1;

        cnt0  = ok0 ? zero_count(w_in.ones, run0) : '0;
        take1 = (w_in.rem >= cnt0);

        w_out.rem   = take1 ? (w_in.rem - cnt0) : w_in.rem;
        w_out.ones  = take1 ? (w_in.ones - 1'b1) : w_in.ones;
        w_out.bit_v = take1;
        w_out.run   = take1 ? run1 : run0;
    end

    assign bit_o = take1;

endmodule

// File: rtl/bwe_unrank.sv
module bwe_unrank
    import bwe_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);

    walk_t chain [CODE_W];
    walk_t tail_unused;

    assign chain[0] = '{rem: CNT_W'(data_i), ones: KW'(ONES), bit_v: 1'b0, run: '0};

    for (genvar s = 0; s < CODE_W; s++) begin : g_step
        if (s < CODE_W - 1) begin : g_mid
            bwe_rank_stage #(.STEP(s)) u_stage (
                .w_in  (chain[s]),
                .w_out (chain[s+1]),
                .bit_o (code_o[CODE_W-1-s])
            );
        end else begin : g_last
            bwe_rank_stage #(.STEP(s)) u_stage (
                .w_in  (chain[s]),
                .w_out (tail_unused),
                .bit_o (code_o[CODE_W-1-s])
            );
        end
    end

endmodule

// File: rtl/bwe_emit_ctrl.sv
module bwe_emit_ctrl
    import bwe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              sync_req,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CODE_W-1:0] fresh_code,
    output logic [CODE_W-1:0] code_o,
    output logic              valid_o
);

    logic [DATA_W-1:0] prev_data;
    logic              prev_ok;
    emit_kind_e        last_kind;
    emit_kind_e        pick;
    logic              fire;
    logic [CODE_W-1:0] word;

    always_comb begin
        fire = 1'b0;
        pick = last_kind;
        if (sync_req) begin
            if (last_kind != EMIT_SYNC) begin
                fire = 1'b1;
                pick = EMIT_SYNC;
            end
        end else if (in_valid) begin
            fire = 1'b1;
            if (prev_ok && data_i == prev_data)
                pick = (last_kind == EMIT_REP0) ? EMIT_REP1 : EMIT_REP0;
            else
                pick = EMIT_DATA;
        end
    end

    always_comb begin
        unique case (pick)
            EMIT_SYNC: word = SYNC_WORD;
            EMIT_REP0: word = REP_WORD0;
            EMIT_REP1: word = REP_WORD1;
            default:   word = fresh_code;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o    <= SYNC_WORD;
            valid_o   <= 1'b0;
            prev_ok   <= 1'b0;
            prev_data <= '0;
            last_kind <= EMIT_SYNC;
        end else begin
            valid_o <= fire;
            if (fire) begin
                code_o    <= word;
                last_kind <= pick;
                if (pick == EMIT_SYNC)
                    prev_ok <= 1'b0;
                else if (pick == EMIT_DATA) begin
                    prev_data <= data_i;
                    prev_ok   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bal_word_enc.sv
module bal_word_enc
    import bwe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              sync_req,
    output logic [CODE_W-1:0] out_code,
    output logic              out_valid
);

    logic [CODE_W-1:0] fresh_code;

    bwe_unrank u_unrank (
        .data_i (in_data),
        .code_o (fresh_code)
    );

    bwe_emit_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .sync_req   (sync_req),
        .data_i     (in_data),
        .fresh_code (fresh_code),
        .code_o     (out_code),
        .valid_o    (out_valid)
    );

endmodule

// File: rtl/bal_word_enc_chk.sv
module bal_word_enc_chk
    import bwe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              sync_req,
    input logic [CODE_W-1:0] out_code,
    input logic              out_valid
);

    logic [CODE_W-1:0] last_code;
    logic              have_last;
    logic              prev_sync;
    logic              cur_is_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_code <= SYNC_WORD;
            have_last <= 1'b0;
            prev_sync <= 1'b1;
        end else if (out_valid) begin
            last_code <= out_code;
            have_last <= 1'b1;
            prev_sync <= (out_code == SYNC_WORD);
        end
    end

    assign cur_is_sync = out_valid ? (out_code == SYNC_WORD) : prev_sync;

    // R1
    balanced_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $countones(out_code) == ONES);

    // R3
    distinct_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && have_last |-> out_code != last_code);

    // R4
    run_limit_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_code != SYNC_WORD |->
            longest_run(out_code) <= RUN_MAX && first_run(out_code) <= LEAD_OFS
            && last_run(out_code) <= EDGE_MAX);

    // R10
    seam_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && have_last && out_code != SYNC_WORD && last_code != SYNC_WORD |->
            !seam_holds_sync({last_code, out_code}));

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && !sync_req |=> out_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid && !sync_req |=> !out_valid && $stable(out_code));

    // R6
    sync_emit_chk: assert property (@(posedge clk) disable iff (rst)
        sync_req && !cur_is_sync |=> out_valid && out_code == SYNC_WORD);

    // R6
    sync_skip_chk: assert property (@(posedge clk) disable iff (rst)
        sync_req && cur_is_sync |=> !out_valid);

    // R7
    after_sync_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && prev_sync |-> out_code != REP_WORD0 && out_code != REP_WORD1);

endmodule

bind bal_word_enc bal_word_enc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .sync_req  (sync_req),
    .out_code  (out_code),
    .out_valid (out_valid)
);

// File: tb/bal_word_enc_tb.sv
module bal_word_enc_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [19:0] T_SYNC = 20'hFF003;
    localparam logic [19:0] T_REPA = 20'hF0F0A;
    localparam logic [19:0] T_REPB = 20'h0F0F5;
    localparam int K_SYNC = 0, K_DATA = 1, K_REPA = 2, K_REPB = 3;

    typedef struct packed {
        logic        v;
        logic        s;
        logic [15:0] d;
    } stim_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        sync_req = 1'b0;
    logic [19:0] out_code;
    logic        out_valid;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    stim_t       q[$];
    logic [19:0] code_of[int];
    bit          need[int];

    int          m_last = K_SYNC;
    bit          m_prev_ok = 0;
    logic [15:0] m_prev_data = '0;
    logic [19:0] m_code = T_SYNC;
    bit          m_valid = 0;
    string       tag;
    bit          have_emit = 0;
    logic [19:0] last_emit = '0;

    bal_word_enc u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .sync_req  (sync_req),
        .out_code  (out_code),
        .out_valid (out_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            report();
        end
    end

    function automatic void run_stats(int w, output int lead, output int trail, output int maxr);
        int run;
        bit changed;
        run = 1;
        maxr = 1;
        lead = 0;
        changed = 0;
        for (int i = 18; i >= 0; i--) begin
            if (w[i] == w[i+1]) run++;
            else begin
                if (!changed) lead = run;
                changed = 1;
                run = 1;
            end
            if (run > maxr) maxr = run;
        end
        if (!changed) lead = run;
        trail = run;
    endfunction

    function automatic bit legal(int w);
        int lead, trail, maxr;
        run_stats(w, lead, trail, maxr);
        return maxr <= 7 && lead <= 3 && trail <= 3;
    endfunction

    task automatic check(bit ok, string req, string what, logic [19:0] got, logic [19:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic model_step(stim_t st);
        if (st.s) begin
            tag = "R6";
            if (m_last != K_SYNC) begin
                m_valid = 1;
                m_code = T_SYNC;
                m_last = K_SYNC;
                m_prev_ok = 0;
            end else m_valid = 0;
        end else if (st.v) begin
            m_valid = 1;
            if (m_prev_ok && st.d == m_prev_data) begin
                tag = "R5";
                if (m_last == K_REPA) begin m_code = T_REPB; m_last = K_REPB; end
                else begin m_code = T_REPA; m_last = K_REPA; end
            end else begin
                tag = (m_last == K_SYNC) ? "R7" : "R2";
                m_code = code_of[int'(st.d)];
                m_last = K_DATA;
                m_prev_data = st.d;
                m_prev_ok = 1;
            end
        end else begin
            tag = "R8";
            m_valid = 0;
        end
    endtask

    task automatic observe();
        int lead, trail, maxr;
        bit seam;
        check(out_valid == m_valid, tag, "out_valid", {19'b0, out_valid}, {19'b0, m_valid});
        check(out_code == m_code, tag, "out_code", out_code, m_code);
        if (out_valid) begin
            check($countones(out_code) == 10, "R1", "ones count", out_code, m_code);
            if (have_emit)
                check(out_code != last_emit, "R3", "repeat of previous word", out_code, last_emit);
            if (out_code != T_SYNC) begin
                run_stats(int'(out_code), lead, trail, maxr);
                check(maxr <= 7 && lead <= 4 && trail <= 3, "R4", "run lengths", out_code, m_code);
                if (have_emit && last_emit != T_SYNC) begin
                    seam = 0;
                    for (int sh = 1; sh < 20; sh++)
                        if ((({last_emit, out_code} >> sh) & 40'hFFFFF) == {20'b0, T_SYNC}) seam = 1;
                    check(!seam, "R10", "sync across seam", out_code, last_emit);
                end
            end
            have_emit = 1;
            last_emit = out_code;
        end
    endtask

    task automatic apply(stim_t st);
        in_valid = st.v;
        sync_req = st.s;
        in_data  = st.d;
        model_step(st);
        @(negedge clk);
        observe();
    endtask

    function automatic stim_t mk(bit v, bit s, int d);
        stim_t t;
        t.v = v;
        t.s = s;
        t.d = d[15:0];
        return t;
    endfunction

    initial begin
        int rank;
        int xs;
        int r;
        int last_d;
        // R9: sync right after reset is suppressed
        q.push_back(mk(0, 1, 0));
        // R2: ordering checks at the ends and middle of the range
        q.push_back(mk(1, 0, 0));
        q.push_back(mk(1, 0, 1));
        q.push_back(mk(1, 0, 2));
        q.push_back(mk(1, 0, 65535));
        q.push_back(mk(1, 0, 65534));
        q.push_back(mk(1, 0, 32768));
        // R5: run of repeats alternates
        q.push_back(mk(1, 0, 5));
        q.push_back(mk(1, 0, 5));
        q.push_back(mk(1, 0, 5));
        q.push_back(mk(1, 0, 5));
        // R8: idle holds, then repeat continues after gap
        q.push_back(mk(0, 0, 0));
        q.push_back(mk(0, 0, 0));
        q.push_back(mk(1, 0, 5));
        // R7: same data after sync uses its ranked code
        q.push_back(mk(0, 1, 0));
        q.push_back(mk(1, 0, 5));
        // R6: back-to-back sync, and sync with data in same cycle
        q.push_back(mk(0, 1, 0));
        q.push_back(mk(1, 1, 77));
        q.push_back(mk(1, 1, 78));
        q.push_back(mk(1, 0, 78));
        q.push_back(mk(1, 0, 78));
        xs = 32'h1D872B41;
        last_d = 78;
        for (int i = 0; i < 240; i++) begin
            xs ^= xs << 13;
            xs ^= xs >>> 17;
            xs ^= xs << 5;
            r = (xs >>> 4) & 15;
            if (r < 2) q.push_back(mk(0, 1, 0));
            else if (r < 4) q.push_back(mk(0, 0, 0));
            else if (r < 8) q.push_back(mk(1, 0, last_d));
            else begin
                if (r == 8) last_d = 0;
                else if (r == 9) last_d = 65535;
                else last_d = (xs >>> 8) & 16'hFFFF;
                q.push_back(mk(1, 0, last_d));
            end
        end

        foreach (q[i]) if (q[i].v) need[int'(q[i].d)] = 1;
        rank = 0;
        for (int w = 0; w < (1 << 20) && rank < 65536; w++) begin
            if ($countones(w) == 10 && legal(w)) begin
                if (need.exists(rank)) code_of[rank] = w[19:0];
                rank++;
            end
        end

        repeat (3) @(negedge clk);
        check(out_code == T_SYNC, "R9", "code in reset", out_code, T_SYNC);
        check(out_valid == 1'b0, "R9", "valid in reset", {19'b0, out_valid}, 20'h0);
        rst = 1'b0;
        foreach (q[i]) apply(q[i]);
        in_valid = 1'b0;
        sync_req = 1'b0;
        done = 1;
        report();
    end

endmodule